// File: doc/BRIEF.md
# Shared-Datapath 16-bit Arithmetic and Logic Unit

This block is a purely combinational arithmetic and logic unit for a 16-bit datapath. It takes two operands and a small set of control fields. It returns one 16-bit result in the same cycle. A single adder/subtractor serves addition, subtraction, increment and decrement. A second-operand mux picks either operand B or the constant one for that adder.

The bitwise AND, OR and XOR results and a barrel shift are all formed in parallel, and a four-way mux picks one of them. One invert mux, driven by a control bit, turns the selected result into its complement. The same mux turns pass-through of A into negation of A. A byte multiplier forms the full 16-bit product of either both low bytes or both high bytes of the operands. The surrounding pipeline supplies the operands and registers the result, so the block has no clock, no reset and no state.

Top module: `alu16_core`

## Requirements
- R1: With op_sel = 3'b000, result is opnd_a + opnd_b when alt_sel = 0 and opnd_a - opnd_b when alt_sel = 1, both modulo 2^16.
- R2: With op_sel = 3'b001, result is opnd_a + 1 when alt_sel = 0 and opnd_a - 1 when alt_sel = 1, modulo 2^16; opnd_b has no effect.
- R3: With op_sel = 3'b010 and inv_sel = 0, logic_sel selects 2'b00 AND, 2'b01 OR, 2'b10 XOR, 2'b11 shift of the operands.
- R4: With op_sel = 3'b010 and inv_sel = 1, result is the bitwise complement of the value R3 gives (NAND, NOR, XNOR, inverted shift).
- R5: The shift (logic_sel = 2'b11) moves opnd_a by shift_ctl[2:0] places (0 to 7), left when shift_ctl[3] = 0 and right when shift_ctl[3] = 1, filling with zeros.
- R6: With op_sel = 3'b011, result is the unsigned 16-bit product of opnd_a[7:0] and opnd_b[7:0] when hi_lane = 0, or of opnd_a[15:8] and opnd_b[15:8] when hi_lane = 1.
- R7: With op_sel = 3'b100, result is opnd_a when inv_sel = 0 and ~opnd_a when inv_sel = 1.
- R8: For op_sel values 3'b101, 3'b110 and 3'b111, result is zero whatever the other inputs are.
- R9: Control fields that do not belong to the selected operation have no effect on result (for example shift_ctl and logic_sel outside op_sel = 3'b010, inv_sel for add and multiply, hi_lane outside multiply).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 16 | First operand, always the adder's first input |
| opnd_b | input | 16 | Second operand |
| op_sel | input | 3 | Operation group select |
| alt_sel | input | 1 | Chooses subtract / decrement within the adder groups |
| inv_sel | input | 1 | Complements the logical result or negates A |
| logic_sel | input | 2 | Logical group member: AND, OR, XOR, shift |
| shift_ctl | input | 4 | Bit 3 direction, bits 2:0 shift distance |
| hi_lane | input | 1 | Multiply lane: 0 low bytes, 1 high bytes |
| result | output | 16 | Operation result |

## Verification
The checker tests, on every change of the inputs, that add, subtract, increment and decrement agree with modular arithmetic on the ports. It also tests that pass and negate follow A, that unused operation codes give zero, that a left shift leaves its low bits clear and that a product never exceeds 255 squared. The complemented logical forms, the exact shift values and product values, and the absence of effect from the control fields of other groups are shown only by the bench. The bench compares every vector against its behavioural model and drives directed corner cases such as wrap-around and the full 7-place shift.

// File: rtl/alu16_pkg.sv
`timescale 1ns/1ps
package alu16_pkg;

    typedef enum logic [2:0] {
        OP_ADDSUB = 3'b000,
        OP_INCDEC = 3'b001,
        OP_LOGIC  = 3'b010,
        OP_MUL    = 3'b011,
        OP_PASS   = 3'b100
    } op_e;

    typedef enum logic [1:0] {
        LG_AND   = 2'b00,
        LG_OR    = 2'b01,
        LG_XOR   = 2'b10,
        LG_SHIFT = 2'b11
    } logic_op_e;

    typedef enum logic [2:0] {
        RS_ARITH,
        RS_LOGIC,
        RS_MUL,
        RS_PASS,
        RS_ZERO
    } res_src_e;

    // Decoded control carried from the decoder to the datapath
    typedef struct packed {
        res_src_e src;
        logic     use_one;
        logic     subtract;
        logic     invert;
    } alu_ctl_t;

    function automatic alu_ctl_t decode_op(input logic [2:0] op, input logic alt, input logic inv);
        alu_ctl_t c;
        c.src      = RS_ZERO;
        c.use_one  = 1'b0;
        c.subtract = 1'b0;
        c.invert   = 1'b0;
        case (op)
            OP_ADDSUB: begin c.src = RS_ARITH; c.subtract = alt; end
            OP_INCDEC: begin c.src = RS_ARITH; c.subtract = alt; c.use_one = 1'b1; end
            OP_LOGIC:  begin c.src = RS_LOGIC; c.invert = inv; end
            OP_MUL:    begin c.src = RS_MUL; end
            OP_PASS:   begin c.src = RS_PASS; c.invert = inv; end
            default:   begin c.src = RS_ZERO; end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alu16_addsub.sv
`timescale 1ns/1ps
module alu16_addsub #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             use_one,
    input  logic             subtract,
    output logic [WIDTH-1:0] sum_out
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] second;
    logic [WIDTH-1:0] second_cond;

    // Second-operand mux, then conditional one's complement plus carry-in
    always_comb begin
        second      = use_one ? ONE : b_in;
        second_cond = subtract ? ~second : second;
        sum_out     = a_in + second_cond + WIDTH'(subtract);
    end
endmodule

// File: rtl/alu16_logic.sv
`timescale 1ns/1ps
module alu16_logic
    import alu16_pkg::*;
#(
    parameter int WIDTH   = 16,
    parameter int SHAMT_W = 3
) (
    input  logic [WIDTH-1:0]   a_in,
    input  logic [WIDTH-1:0]   b_in,
    input  logic [1:0]         sel,
    input  logic [SHAMT_W:0]   shift_ctl,
    output logic [WIDTH-1:0]   y_out
);
    localparam int STAGES = SHAMT_W;

    logic             go_right;
    logic [WIDTH-1:0] stage [0:STAGES];
    logic [WIDTH-1:0] and_v, or_v, xor_v;

    assign go_right = shift_ctl[SHAMT_W];
    assign stage[0] = a_in;

    // Logarithmic barrel shifter: stage i moves by 2**i when its bit is set
    for (genvar i = 0; i < STAGES; i++) begin : g_shift
        localparam int DIST = 1 << i;
        always_comb begin
            if (!shift_ctl[i])
                stage[i+1] = stage[i];
            else if (go_right)
                stage[i+1] = stage[i] >> DIST;
            else
                stage[i+1] = stage[i] << DIST;
        end
    end

    always_comb begin
        and_v = a_in & b_in;
        or_v  = a_in | b_in;
        xor_v = a_in ^ b_in;
        case (logic_op_e'(sel))
            LG_AND:  y_out = and_v;
            LG_OR:   y_out = or_v;
            LG_XOR:  y_out = xor_v;
            default: y_out = stage[STAGES];
        endcase
    end
endmodule

// File: rtl/alu16_mul.sv
`timescale 1ns/1ps
module alu16_mul #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             hi_lane,
    output logic [WIDTH-1:0] prod_out
);
    localparam int HALF = WIDTH / 2;

    logic [HALF-1:0] a_lane, b_lane;

    // Matching lanes only: both low halves or both high halves
    always_comb begin
        a_lane   = hi_lane ? a_in[WIDTH-1:HALF] : a_in[HALF-1:0];
        b_lane   = hi_lane ? b_in[WIDTH-1:HALF] : b_in[HALF-1:0];
        prod_out = WIDTH'(a_lane) * WIDTH'(b_lane);
    end
endmodule

// File: rtl/alu16_core.sv
`timescale 1ns/1ps
module alu16_core
    import alu16_pkg::*;
#(
    parameter int WIDTH   = 16,
    parameter int SHAMT_W = 3
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [2:0]       op_sel,
    input  logic             alt_sel,
    input  logic             inv_sel,
    input  logic [1:0]       logic_sel,
    input  logic [SHAMT_W:0] shift_ctl,
    input  logic             hi_lane,
    output logic [WIDTH-1:0] result
);
    alu_ctl_t         ctl;
    logic [WIDTH-1:0] arith_v, logic_v, mul_v, chosen;

    assign ctl = decode_op(op_sel, alt_sel, inv_sel);

    alu16_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a_in     (opnd_a),
        .b_in     (opnd_b),
        .use_one  (ctl.use_one),
        .subtract (ctl.subtract),
        .sum_out  (arith_v)
    );

    alu16_logic #(.WIDTH(WIDTH), .SHAMT_W(SHAMT_W)) u_logic (
        .a_in      (opnd_a),
        .b_in      (opnd_b),
        .sel       (logic_sel),
        .shift_ctl (shift_ctl),
        .y_out     (logic_v)
    );

    alu16_mul #(.WIDTH(WIDTH)) u_mul (
        .a_in     (opnd_a),
        .b_in     (opnd_b),
        .hi_lane  (hi_lane),
        .prod_out (mul_v)
    );

    // Result select followed by the shared invert mux
    always_comb begin
        case (ctl.src)
            RS_ARITH: chosen = arith_v;
            RS_LOGIC: chosen = logic_v;
            RS_MUL:   chosen = mul_v;
            RS_PASS:  chosen = opnd_a;
            default:  chosen = '0;
        endcase
        result = ctl.invert ? ~chosen : chosen;
    end
endmodule

// File: rtl/alu16_core_chk.sv
`timescale 1ns/1ps
module alu16_core_chk #(
    parameter int WIDTH   = 16,
    parameter int SHAMT_W = 3
) (
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [2:0]       op_sel,
    input logic             alt_sel,
    input logic             inv_sel,
    input logic [1:0]       logic_sel,
    input logic [SHAMT_W:0] shift_ctl,
    input logic             hi_lane,
    input logic [WIDTH-1:0] result
);
    localparam int HALF = WIDTH / 2;
    localparam logic [WIDTH-1:0] MAX_PROD = WIDTH'(((1 << HALF) - 1) * ((1 << HALF) - 1));

    logic             known;
    logic [WIDTH-1:0] low_mask;

    always_comb begin
        known = !$isunknown({opnd_a, opnd_b, op_sel, alt_sel, inv_sel,
                             logic_sel, shift_ctl, hi_lane, result});
        low_mask = WIDTH'((1 << shift_ctl[SHAMT_W-1:0]) - 1);
        if (known) begin
            if (op_sel == 3'b000 && !alt_sel)
                p_add_wrap_r1: assert (result == WIDTH'(opnd_a + opnd_b));
            if (op_sel == 3'b000 && alt_sel)
                p_sub_wrap_r1: assert (WIDTH'(result + opnd_b) == opnd_a);
            if (op_sel == 3'b001 && !alt_sel)
                p_inc_wrap_r2: assert (WIDTH'(result - WIDTH'(1)) == opnd_a);
            if (op_sel == 3'b001 && alt_sel)
                p_dec_wrap_r2: assert (WIDTH'(result + WIDTH'(1)) == opnd_a);
            if (op_sel == 3'b010 && logic_sel == 2'b11 && !inv_sel && !shift_ctl[SHAMT_W])
                p_left_fill_r5: assert ((result & low_mask) == '0);
            if (op_sel == 3'b011)
                p_prod_bound_r6: assert (result <= MAX_PROD);
            if (op_sel == 3'b100)
                p_pass_neg_r7: assert (result == (inv_sel ? ~opnd_a : opnd_a));
            if (op_sel > 3'b100)
                p_unused_zero_r8: assert (result == '0);
        end
    end
endmodule

bind alu16_core alu16_core_chk #(.WIDTH(WIDTH), .SHAMT_W(SHAMT_W)) i_chk (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .op_sel    (op_sel),
    .alt_sel   (alt_sel),
    .inv_sel   (inv_sel),
    .logic_sel (logic_sel),
    .shift_ctl (shift_ctl),
    .hi_lane   (hi_lane),
    .result    (result)
);

// File: tb/test_alu16_core.sv
`timescale 1ns/1ps
module test_alu16_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] opnd_a = '0, opnd_b = '0;
    logic [2:0]  op_sel = '0;
    logic        alt_sel = 1'b0, inv_sel = 1'b0, hi_lane = 1'b0;
    logic [1:0]  logic_sel = '0;
    logic [3:0]  shift_ctl = '0;
    logic [15:0] result;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    alu16_core i_alu16_core (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel), .alt_sel(alt_sel),
        .inv_sel(inv_sel), .logic_sel(logic_sel), .shift_ctl(shift_ctl),
        .hi_lane(hi_lane), .result(result)
    );

    // Behavioural model built from the requirements with plain integers
    function automatic int unsigned model(int unsigned a, int unsigned b, int op, bit alt,
                                          bit inv, int ls, int sh, bit hi);
        int unsigned r;
        int amt;
        amt = sh % 8;
        case (op)
            0: r = alt ? (a + 65536 - b) : (a + b);
            1: r = alt ? (a + 65535) : (a + 1);
            2: begin
                case (ls)
                    0: r = a & b;
                    1: r = a | b;
                    2: r = a ^ b;
                    default: r = (sh >= 8) ? (a / (1 << amt)) : (a * (1 << amt));
                endcase
                if (inv) r = ~r;
            end
            3: r = hi ? ((a / 256) * (b / 256)) : ((a % 256) * (b % 256));
            4: r = inv ? ~a : a;
            default: r = 0;
        endcase
        return r % 65536;
    endfunction

    task automatic check(string tag, int unsigned exp);
        n_tests++;
        if (result !== 16'(exp)) begin
            n_fail++;
            $display("FAIL %s: result=%h expected=%h (op=%0d alt=%0b inv=%0b ls=%0d sh=%h hi=%0b a=%h b=%h)",
                     tag, result, 16'(exp), op_sel, alt_sel, inv_sel, logic_sel, shift_ctl,
                     hi_lane, opnd_a, opnd_b);
        end
    endtask

    // Drive at the falling edge, compare one time unit later
    task automatic run(string tag, logic [15:0] a, logic [15:0] b, int op, bit alt, bit inv,
                       int ls, int sh, bit hi);
        @(negedge clk);
        opnd_a = a; opnd_b = b; op_sel = 3'(op); alt_sel = alt; inv_sel = inv;
        logic_sel = 2'(ls); shift_ctl = 4'(sh); hi_lane = hi;
        #1;
        check(tag, model(a, b, op, alt, inv, ls, sh, hi));
    endtask

    function automatic string tag_of(int op, bit inv, int ls);
        case (op)
            0: return "R1";
            1: return "R2";
            2: return (ls == 3) ? "R5" : (inv ? "R4" : "R3");
            3: return "R6";
            4: return "R7";
            default: return "R8";
        endcase
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: expired, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check("R1 idle zero inputs", 0);
        rst = 1'b0;

        // R1 corners
        run("R1 add wrap", 16'hFFFF, 16'h0001, 0, 0, 0, 0, 0, 0);
        run("R1 sub wrap", 16'h0000, 16'h0001, 0, 1, 0, 0, 0, 0);
        run("R1 sub", 16'h1234, 16'h0234, 0, 1, 0, 0, 0, 0);
        // R2 corners
        run("R2 inc wrap", 16'hFFFF, 16'h5555, 1, 0, 0, 0, 0, 0);
        run("R2 dec wrap", 16'h0000, 16'h5555, 1, 1, 0, 0, 0, 0);
        // R3 / R4
        run("R3 and", 16'hF0F0, 16'hFF00, 2, 0, 0, 0, 0, 0);
        run("R3 or",  16'hF0F0, 16'h0F00, 2, 0, 0, 1, 0, 0);
        run("R3 xor", 16'hF0F0, 16'hFF00, 2, 0, 0, 2, 0, 0);
        run("R4 nand", 16'hF0F0, 16'hFF00, 2, 0, 1, 0, 0, 0);
        run("R4 nor",  16'hF0F0, 16'h0F00, 2, 0, 1, 1, 0, 0);
        run("R4 xnor", 16'hF0F0, 16'hFF00, 2, 0, 1, 2, 0, 0);
        // R5 shifts
        run("R5 left 7",  16'hFFFF, 16'h0000, 2, 0, 0, 3, 7, 0);
        run("R5 right 7", 16'h8000, 16'h0000, 2, 0, 0, 3, 15, 0);
        run("R5 left 0",  16'hABCD, 16'h0000, 2, 0, 0, 3, 0, 0);
        run("R5 right 1", 16'h0003, 16'h0000, 2, 0, 0, 3, 9, 0);
        // R6 lanes
        run("R6 low ff*ff", 16'h12FF, 16'h34FF, 3, 0, 0, 0, 0, 0);
        run("R6 high ff*ff", 16'hFF12, 16'hFF34, 3, 0, 0, 0, 0, 1);
        run("R6 high 02*03", 16'h02FF, 16'h03FF, 3, 0, 0, 0, 0, 1);
        // R7
        run("R7 pass", 16'hA5C3, 16'hFFFF, 4, 0, 0, 0, 0, 0);
        run("R7 negate", 16'hA5C3, 16'hFFFF, 4, 0, 1, 0, 0, 0);
        // R8
        for (int op = 5; op < 8; op++)
            run("R8 unused op", 16'hFFFF, 16'hFFFF, op, 1, 1, 3, 9, 1);
        // R9: fields of other groups must not disturb the result
        run("R9 inc ignores b/shift", 16'h00FF, 16'hFFFF, 1, 0, 0, 3, 15, 1);
        run("R9 add ignores inv/hi", 16'h0100, 16'h0001, 0, 0, 1, 2, 5, 1);
        run("R9 mul ignores inv/shift", 16'h0010, 16'h0010, 3, 1, 1, 3, 12, 0);
        run("R9 logic ignores hi/alt", 16'h00F0, 16'h0F00, 2, 1, 0, 1, 0, 1);

        // Mixed vectors, every operation group
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a, b;
            int op, ls, sh;
            bit alt, inv, hi;
            a = 16'($urandom); b = 16'($urandom);
            op = int'($urandom % 8); ls = int'($urandom % 4); sh = int'($urandom % 16);
            alt = 1'($urandom); inv = 1'($urandom); hi = 1'($urandom);
            run(tag_of(op, inv, ls), a, b, op, alt, inv, ls, sh, hi);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule